// File: doc/BRIEF.md
# Cipher Engine Scheduler with Shared Key Slots

This block sits between a set of storage ports and a small pool of cipher engines. Each port asks for a stream to be encrypted (outgoing writes) or decrypted (incoming reads) with the key held in one slot of a shared slot file. The block binds the port to one engine for the whole stream. It does this only when four things hold in the same cycle: the port's data source is ready, its output path is ready, the named slot holds a valid key, and an engine is idle. The binding lasts until the engine signals that the stream is finished.

The slot file is loaded by a management controller through a simple write port. The controller writes a slot when the system starts and again each time a drive appears. Each slot records whether it holds a key and whether that key is 128 or 256 bits long. Any engine can read any slot. A write aimed at a slot that a running engine is using is not taken: the block lowers its accept signal and the controller holds the write until the engine has let go. The cipher datapath itself is outside this block. It is represented by a start pulse and a done input on each engine.

Top module: `cipher_sched`

## Requirements
- R1: A slot write with `kw_valid` high and `kw_accept` high stores the key, the length flag and the `kw_enable` validity bit into slot `kw_slot` at that clock edge. An engine later bound to that slot presents that key on its `eng_key` lane.
- R2: `eng_key_long` equals the length flag of the engine's slot (1 = 256-bit key). For a 128-bit key, the upper half of the `eng_key` lane reads zero and the lower half holds the stored key bits.
- R3: An unbound port whose request names an invalid slot gets no grant and shows `port_err` high in the cycle after. An invalid slot is one never written, one last written with `kw_enable` = 0, or an index of 6 or 7.
- R4: A port is granted only after a cycle in which `req_valid`, `src_ready` and `dst_ready` were all high, its slot was valid, and at least one engine was idle.
- R5: Once bound, a port keeps `port_grant` high and its engine keeps the same `eng_port` and key. This lasts until a cycle in which that engine's `eng_done` is high. After that edge the engine is idle and the port's grant is low.
- R6: A new binding raises `eng_start` of the chosen engine for exactly one cycle, together with `eng_active`. `eng_encrypt` equals the port's `req_encrypt` (1 = encrypt a write, 0 = decrypt a read).
- R7: At most one binding is made per cycle. It uses the lowest-numbered idle engine, and `port_eng` of the granted port reports that engine's index.
- R8: Among eligible ports, the grant goes to the first one found cyclically after the most recently granted port. After reset the search starts at port 0.
- R9: A slot write that targets a slot used by an active engine has `kw_accept` low and leaves the slot unchanged. The write is accepted in the first cycle after the engine is released.
- R10: A port whose slot is the target of `kw_valid` in the current cycle is not granted in that cycle.
- R11: After reset, all slots are invalid, all engines are idle, and no port is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kw_valid | input | 1 | Slot write request from the management controller |
| kw_slot | input | 3 | Slot index to write |
| kw_key | input | 256 | Key value; a 128-bit key uses the low half |
| kw_long | input | 1 | 1 = 256-bit key, 0 = 128-bit key |
| kw_enable | input | 1 | Validity bit stored with the key |
| kw_accept | output | 1 | Write taken at this edge; low while the slot is in use |
| req_valid | input | 6 | Per-port stream request |
| req_encrypt | input | 6 | Per-port direction, 1 = encrypt (write), 0 = decrypt (read) |
| req_slot | input | 18 | Per-port slot index, 3 bits per port |
| src_ready | input | 6 | Per-port data source available |
| dst_ready | input | 6 | Per-port output path available |
| port_grant | output | 6 | Port is bound to an engine |
| port_err | output | 6 | Request named an invalid slot |
| port_eng | output | 12 | Bound engine index, 2 bits per port |
| eng_done | input | 3 | Engine has finished its stream |
| eng_start | output | 3 | One-cycle pulse when an engine is bound |
| eng_active | output | 3 | Engine carries a stream |
| eng_encrypt | output | 3 | Engine direction, 1 = encrypt |
| eng_key_long | output | 3 | Length flag of the engine's key |
| eng_key | output | 768 | Key lane per engine, 256 bits each |
| eng_port | output | 9 | Port bound to each engine, 3 bits each |
| eng_slot | output | 9 | Slot used by each engine, 3 bits each |

## Verification
A lone request on a valid slot checks the basic binding, key delivery and direction. A short-key slot separates the length handling from the long-key path. Requests naming a never-written slot, a disabled slot and an out-of-range index show that the error path is distinct from mere waiting. A request held back only by its output path shows that readiness alone gates the grant. With all engines full, a key write to an in-use slot, followed by an engine release, shows three things: that the write is held, that it lands afterwards, and that a port naming that slot waits out the write cycle. Finally, three simultaneous requests after a known last grant show the round-robin order and the lowest-idle-engine choice together.

// File: rtl/cs_pkg.sv
package cs_pkg;
    parameter int CS_NPORT = 6;
    parameter int CS_NENG  = 3;
    parameter int CS_NSLOT = 6;
    parameter int CS_KEY_W = 256;

    typedef enum logic {
        DIR_DECRYPT = 1'b0,
        DIR_ENCRYPT = 1'b1
    } cs_dir_e;

    function automatic int cs_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/cs_rr_pick.sv
// Cyclic first-one search starting just after index `last`.
module cs_rr_pick #(
    parameter int N = cs_pkg::CS_NPORT,
    parameter int W = cs_pkg::cs_idx_w(N)
) (
    input  logic [N-1:0] elig,
    input  logic [W-1:0] last,
    output logic         found,
    output logic [W-1:0] pick
);
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last) + k) % N;
            if (!found && elig[idx]) begin
                found = 1'b1;
                pick  = W'(idx);
            end
        end
    end
endmodule

// File: rtl/cs_key_bank.sv
// Shared key slot file: one write port, one read lane per engine.
module cs_key_bank #(
    parameter int NSLOT  = cs_pkg::CS_NSLOT,
    parameter int NENG   = cs_pkg::CS_NENG,
    parameter int KEY_W  = cs_pkg::CS_KEY_W,
    parameter int SLOT_W = cs_pkg::cs_idx_w(NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   kw_valid,
    input  logic [SLOT_W-1:0]      kw_slot,
    input  logic [KEY_W-1:0]       kw_key,
    input  logic                   kw_long,
    input  logic                   kw_enable,
    input  logic [NSLOT-1:0]       slot_busy,
    output logic                   kw_accept,
    output logic [NSLOT-1:0]       slot_valid,
    input  logic [NENG*SLOT_W-1:0] rd_slot,
    output logic [NENG*KEY_W-1:0]  rd_key,
    output logic [NENG-1:0]        rd_long
);
    localparam int HALF_W = KEY_W / 2;
    localparam logic [SLOT_W:0] SLOT_LIM = (SLOT_W+1)'(NSLOT);

    typedef struct packed {
        logic             vld;
        logic             lng;
        logic [KEY_W-1:0] key;
    } slot_t;

    typedef struct packed {
        slot_t [NSLOT-1:0] s;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  wr_ok;

    always_comb begin
        bank_d = bank_q;
        wr_ok  = 1'b0;
        if (kw_valid && ({1'b0, kw_slot} < SLOT_LIM)) begin
            wr_ok = !slot_busy[kw_slot];
        end
        if (wr_ok) begin
            bank_d.s[kw_slot].vld = kw_enable;
            bank_d.s[kw_slot].lng = kw_long;
            bank_d.s[kw_slot].key = kw_key;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign kw_accept = wr_ok;

    for (genvar s = 0; s < NSLOT; s++) begin : g_vld
        assign slot_valid[s] = bank_q.s[s].vld;
    end

    for (genvar e = 0; e < NENG; e++) begin : g_rd
        logic [SLOT_W-1:0] idx;
        slot_t             ent;
        assign idx = rd_slot[e*SLOT_W +: SLOT_W];
        assign ent = ({1'b0, idx} < SLOT_LIM) ? bank_q.s[idx] : '0;
        assign rd_long[e] = ent.lng;
        assign rd_key[e*KEY_W +: KEY_W] = ent.lng ? ent.key
                                        : {{(KEY_W-HALF_W){1'b0}}, ent.key[HALF_W-1:0]};
    end
endmodule

// File: rtl/cipher_sched.sv
module cipher_sched #(
    parameter int NPORT  = cs_pkg::CS_NPORT,
    parameter int NENG   = cs_pkg::CS_NENG,
    parameter int NSLOT  = cs_pkg::CS_NSLOT,
    parameter int KEY_W  = cs_pkg::CS_KEY_W,
    parameter int SLOT_W = cs_pkg::cs_idx_w(NSLOT),
    parameter int ENG_W  = cs_pkg::cs_idx_w(NENG),
    parameter int PORT_W = cs_pkg::cs_idx_w(NPORT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    kw_valid,
    input  logic [SLOT_W-1:0]       kw_slot,
    input  logic [KEY_W-1:0]        kw_key,
    input  logic                    kw_long,
    input  logic                    kw_enable,
    output logic                    kw_accept,
    input  logic [NPORT-1:0]        req_valid,
    input  logic [NPORT-1:0]        req_encrypt,
    input  logic [NPORT*SLOT_W-1:0] req_slot,
    input  logic [NPORT-1:0]        src_ready,
    input  logic [NPORT-1:0]        dst_ready,
    output logic [NPORT-1:0]        port_grant,
    output logic [NPORT-1:0]        port_err,
    output logic [NPORT*ENG_W-1:0]  port_eng,
    input  logic [NENG-1:0]         eng_done,
    output logic [NENG-1:0]         eng_start,
    output logic [NENG-1:0]         eng_active,
    output logic [NENG-1:0]         eng_encrypt,
    output logic [NENG-1:0]         eng_key_long,
    output logic [NENG*KEY_W-1:0]   eng_key,
    output logic [NENG*PORT_W-1:0]  eng_port,
    output logic [NENG*SLOT_W-1:0]  eng_slot
);
    localparam logic [SLOT_W:0] SLOT_LIM = (SLOT_W+1)'(NSLOT);

    typedef struct packed {
        logic [NENG-1:0]              active;
        logic [NENG-1:0]              start;
        logic [NENG-1:0]              enc;
        logic [NENG-1:0][PORT_W-1:0]  port;
        logic [NENG-1:0][SLOT_W-1:0]  slot;
        logic [NPORT-1:0]             bound;
        logic [NPORT-1:0][ENG_W-1:0]  peng;
        logic [NPORT-1:0]             err;
        logic [PORT_W-1:0]            last;
    } sched_t;

    sched_t st_d, st_q;

    logic [NPORT-1:0][SLOT_W-1:0] slot_idx;
    logic [NPORT-1:0]             port_elig;
    logic [NPORT-1:0]             port_bad;
    logic [NSLOT-1:0]             slot_busy;
    logic [NSLOT-1:0]             slot_valid;
    logic                         port_found, eng_found;
    logic [PORT_W-1:0]            port_pick;
    logic [ENG_W-1:0]             eng_pick;

    for (genvar p = 0; p < NPORT; p++) begin : g_idx
        assign slot_idx[p] = req_slot[p*SLOT_W +: SLOT_W];
    end

    // Eligibility of each port and occupancy of each slot
    always_comb begin
        logic ok;
        for (int p = 0; p < NPORT; p++) begin
            ok = 1'b0;
            if ({1'b0, slot_idx[p]} < SLOT_LIM) ok = slot_valid[slot_idx[p]];
            port_bad[p]  = req_valid[p] && !st_q.bound[p] && !ok;
            port_elig[p] = req_valid[p] && !st_q.bound[p] && ok
                           && !(kw_valid && (kw_slot == slot_idx[p]))
                           && src_ready[p] && dst_ready[p];
        end
        for (int s = 0; s < NSLOT; s++) begin
            slot_busy[s] = 1'b0;
            for (int e = 0; e < NENG; e++) begin
                if (st_q.active[e] && (st_q.slot[e] == SLOT_W'(s))) slot_busy[s] = 1'b1;
            end
        end
    end

    cs_rr_pick #(.N(NPORT), .W(PORT_W)) u_port_pick (
        .elig  (port_elig),
        .last  (st_q.last),
        .found (port_found),
        .pick  (port_pick)
    );

    // Searching from the top index makes this a lowest-first pick.
    cs_rr_pick #(.N(NENG), .W(ENG_W)) u_eng_pick (
        .elig  (~st_q.active),
        .last  (ENG_W'(NENG-1)),
        .found (eng_found),
        .pick  (eng_pick)
    );

    cs_key_bank #(.NSLOT(NSLOT), .NENG(NENG), .KEY_W(KEY_W), .SLOT_W(SLOT_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .kw_valid   (kw_valid),
        .kw_slot    (kw_slot),
        .kw_key     (kw_key),
        .kw_long    (kw_long),
        .kw_enable  (kw_enable),
        .slot_busy  (slot_busy),
        .kw_accept  (kw_accept),
        .slot_valid (slot_valid),
        .rd_slot    (st_q.slot),
        .rd_key     (eng_key),
        .rd_long    (eng_key_long)
    );

    // Next state: releases, errors, then at most one new binding
    always_comb begin
        st_d       = st_q;
        st_d.start = '0;
        st_d.err   = port_bad;
        for (int e = 0; e < NENG; e++) begin
            if (st_q.active[e] && eng_done[e]) begin
                st_d.active[e]             = 1'b0;
                st_d.bound[st_q.port[e]]   = 1'b0;
            end
        end
        if (port_found && eng_found) begin
            st_d.active[eng_pick] = 1'b1;
            st_d.start[eng_pick]  = 1'b1;
            st_d.enc[eng_pick]    = req_encrypt[port_pick];
            st_d.port[eng_pick]   = port_pick;
            st_d.slot[eng_pick]   = slot_idx[port_pick];
            st_d.bound[port_pick] = 1'b1;
            st_d.peng[port_pick]  = eng_pick;
            st_d.last             = port_pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= PORT_W'(NPORT-1);
        end else begin
            st_q <= st_d;
        end
    end

    assign port_grant  = st_q.bound;
    assign port_err    = st_q.err;
    assign port_eng    = st_q.peng;
    assign eng_start   = st_q.start;
    assign eng_active  = st_q.active;
    assign eng_encrypt = st_q.enc;
    assign eng_port    = st_q.port;
    assign eng_slot    = st_q.slot;
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
    parameter int NPORT  = 6,
    parameter int NENG   = 3,
    parameter int SLOT_W = 3,
    parameter int PORT_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   kw_valid,
    input logic [SLOT_W-1:0]      kw_slot,
    input logic                   kw_accept,
    input logic [NPORT-1:0]       req_valid,
    input logic [NPORT-1:0]       src_ready,
    input logic [NPORT-1:0]       dst_ready,
    input logic [NPORT-1:0]       port_grant,
    input logic [NPORT-1:0]       port_err,
    input logic [NENG-1:0]        eng_start,
    input logic [NENG-1:0]        eng_active,
    input logic [NENG*PORT_W-1:0] eng_port,
    input logic [NENG*SLOT_W-1:0] eng_slot
);
    logic [NENG-1:0] in_use_hit;
    always_comb begin
        for (int e = 0; e < NENG; e++)
            in_use_hit[e] = eng_active[e] && (eng_slot[e*SLOT_W +: SLOT_W] == kw_slot);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // R4
        grant_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_grant[p]) |-> $past(req_valid[p] && src_ready[p] && dst_ready[p]));
        // R3
        err_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_err[p] |-> !port_grant[p]);
    end

    for (genvar e = 0; e < NENG; e++) begin : g_eng
        // R5
        port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (eng_active[e] && $past(eng_active[e])) |-> $stable(eng_port[e*PORT_W +: PORT_W]));
        // R6
        start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[e] |=> !eng_start[e]);
        // R6
        start_binds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[e] |-> (eng_active[e] && !$past(eng_active[e])));
    end

    // R7
    one_bind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(eng_start) <= 1);
    // R9
    held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kw_accept |-> (kw_valid && (in_use_hit == '0)));
endmodule

bind cipher_sched cs_checker #(
    .NPORT(NPORT), .NENG(NENG), .SLOT_W(SLOT_W), .PORT_W(PORT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .kw_valid   (kw_valid),
    .kw_slot    (kw_slot),
    .kw_accept  (kw_accept),
    .req_valid  (req_valid),
    .src_ready  (src_ready),
    .dst_ready  (dst_ready),
    .port_grant (port_grant),
    .port_err   (port_err),
    .eng_start  (eng_start),
    .eng_active (eng_active),
    .eng_port   (eng_port),
    .eng_slot   (eng_slot)
);

// File: tb/cipher_sched_tb.sv
module cipher_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;
    localparam int NE = 3;
    localparam int SW = 3;
    localparam int EW = 2;
    localparam int PW = 3;
    localparam int KW = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kw_valid = 1'b0;
    logic [SW-1:0] kw_slot = '0;
    logic [KW-1:0] kw_key = '0;
    logic kw_long = 1'b0;
    logic kw_enable = 1'b0;
    logic kw_accept;
    logic [NP-1:0] req_valid = '0;
    logic [NP-1:0] req_encrypt = '0;
    logic [NP*SW-1:0] req_slot = '0;
    logic [NP-1:0] src_ready = '0;
    logic [NP-1:0] dst_ready = '0;
    logic [NP-1:0] port_grant, port_err;
    logic [NP*EW-1:0] port_eng;
    logic [NE-1:0] eng_done = '0;
    logic [NE-1:0] eng_start, eng_active, eng_encrypt, eng_key_long;
    logic [NE*KW-1:0] eng_key;
    logic [NE*PW-1:0] eng_port;
    logic [NE*SW-1:0] eng_slot;

    always #(CLK_PERIOD/2) clk = ~clk;

    cipher_sched u_dut (.*);

    typedef struct {
        int            port;
        int            eng;
        logic [KW-1:0] key;
        logic          lng;
        logic          enc;
    } exp_t;
    exp_t sbq[$];
    exp_t mon_it;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    localparam logic [KW-1:0] K0  = {4{64'h0123_4567_89ab_cdef}};
    localparam logic [KW-1:0] K1  = {4{64'hfeed_face_cafe_0001}};
    localparam logic [KW-1:0] K1S = {128'b0, K1[127:0]};
    localparam logic [KW-1:0] K2  = {4{64'h0f0f_1e1e_2d2d_3c3c}};
    localparam logic [KW-1:0] K3  = {4{64'h7777_0000_7777_0000}};
    localparam logic [KW-1:0] K0B = {4{64'h5555_aaaa_3333_cccc}};

    task automatic chk(input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_key(input int s, input logic [KW-1:0] k, input logic lng, input logic en);
        @(negedge clk);
        kw_valid = 1'b1; kw_slot = SW'(s); kw_key = k; kw_long = lng; kw_enable = en;
        #1 chk("R1 write accepted", kw_accept, 1);
        @(negedge clk);
        kw_valid = 1'b0;
    endtask

    task automatic req(input int p, input int s, input logic enc, input logic src, input logic dst);
        req_valid[p] = 1'b1;
        req_encrypt[p] = enc;
        req_slot[p*SW +: SW] = SW'(s);
        src_ready[p] = src;
        dst_ready[p] = dst;
    endtask

    task automatic expect_bind(input int p, input int e, input logic [KW-1:0] k,
                               input logic lng, input logic enc);
        exp_t it;
        it.port = p; it.eng = e; it.key = k; it.lng = lng; it.enc = enc;
        sbq.push_back(it);
    endtask

    // Monitor: every engine start is compared with the next expected binding
    always @(negedge clk) begin
        if (rst_n) begin
            for (int e = 0; e < NE; e++) begin
                if (eng_start[e]) begin
                    if (sbq.size() == 0) begin
                        chk("R6 unexpected start", 1, 0);
                    end else begin
                        mon_it = sbq.pop_front();
                        chk("R7 engine choice", e, mon_it.eng);
                        chk("R8 bound port", eng_port[e*PW +: PW], mon_it.port);
                        chk("R1 key lane", eng_key[e*KW +: KW], mon_it.key);
                        chk("R2 key length", eng_key_long[e], mon_it.lng);
                        chk("R6 direction", eng_encrypt[e], mon_it.enc);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 grants", port_grant, 0);
        chk("R11 engines", eng_active, 0);
        chk("R11 starts", eng_start, 0);
        rst_n = 1'b1;

        // R11: slots empty after reset, so a request errors
        @(negedge clk);
        req(0, 0, 1, 1, 1);
        @(negedge clk);
        chk("R11 slot empty err", port_err[0], 1);
        chk("R11 slot empty no grant", port_grant[0], 0);
        req_valid[0] = 1'b0;

        wr_key(0, K0, 1, 1);
        wr_key(1, K1, 0, 1);
        wr_key(2, K2, 1, 1);
        wr_key(3, K3, 1, 0);

        // R1 R6: lone encrypt request
        @(negedge clk);
        req(0, 0, 1, 1, 1);
        expect_bind(0, 0, K0, 1, 1);
        @(negedge clk);
        chk("R4 grant port0", port_grant[0], 1);
        chk("R7 port0 engine", port_eng[0*EW +: EW], 0);
        @(negedge clk);
        chk("R6 start one cycle", eng_start[0], 0);
        chk("R5 still active", eng_active[0], 1);

        // R2: short key, decrypt
        req(2, 1, 0, 1, 1);
        expect_bind(2, 1, K1S, 0, 0);
        @(negedge clk);
        chk("R7 port2 engine", port_eng[2*EW +: EW], 1);

        // R3: disabled slot and out-of-range index
        req(3, 3, 1, 1, 1);
        req(4, 7, 1, 1, 1);
        @(negedge clk);
        chk("R3 disabled slot err", port_err[3], 1);
        chk("R3 range err", port_err[4], 1);
        chk("R3 no grant", port_grant[4:3], 0);
        chk("R3 engine left idle", eng_active[2], 0);
        req_valid[3] = 1'b0;
        req_valid[4] = 1'b0;

        // R4: output path not ready
        req(5, 2, 1, 1, 0);
        repeat (3) @(negedge clk);
        chk("R4 dst not ready", port_grant[5], 0);
        chk("R4 engine idle", eng_active[2], 0);
        dst_ready[5] = 1'b1;
        expect_bind(5, 2, K2, 1, 1);
        @(negedge clk);
        chk("R4 granted when ready", port_grant[5], 1);

        // R5: binding survives source stalls
        src_ready[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 grant held", port_grant[0], 1);
        chk("R5 port held", eng_port[0*PW +: PW], 0);
        src_ready[0] = 1'b1;

        // R4 no idle engine; R9 held write; R10 write-cycle hold
        req(1, 0, 1, 1, 1);
        @(negedge clk);
        chk("R4 no idle engine", port_grant[1], 0);
        kw_valid = 1'b1; kw_slot = 3'd0; kw_key = K0B; kw_long = 1'b1; kw_enable = 1'b1;
        #1 chk("R9 write held", kw_accept, 0);
        @(negedge clk);
        chk("R9 key unchanged", eng_key[0 +: KW], K0);
        chk("R9 still held", kw_accept, 0);
        eng_done[0] = 1'b1;
        req_valid[0] = 1'b0;
        #1 chk("R9 held at release", kw_accept, 0);
        @(negedge clk);
        eng_done[0] = 1'b0;
        #1 chk("R9 write taken", kw_accept, 1);
        chk("R5 released", eng_active[0], 0);
        chk("R5 grant dropped", port_grant[0], 0);
        @(negedge clk);
        kw_valid = 1'b0;
        chk("R10 no grant in write cycle", port_grant[1], 0);
        expect_bind(1, 0, K0B, 1, 1);
        @(negedge clk);
        chk("R10 granted after write", port_grant[1], 1);
        chk("R7 port1 engine", port_eng[1*EW +: EW], 0);

        // R8: release all, then three ports at once; last grant was port 1
        @(negedge clk);
        eng_done = 3'b111;
        req_valid = '0;
        @(negedge clk);
        eng_done = '0;
        chk("R5 all idle", eng_active, 0);
        chk("R5 all released", port_grant, 0);
        req(0, 2, 1, 1, 1);
        req(2, 0, 0, 1, 1);
        req(4, 1, 1, 1, 1);
        expect_bind(2, 0, K0B, 1, 0);
        expect_bind(4, 1, K1S, 0, 1);
        expect_bind(0, 2, K2, 1, 1);
        @(negedge clk);
        chk("R8 first pick", port_grant, 6'b000100);
        @(negedge clk);
        chk("R8 second pick", port_grant, 6'b010100);
        @(negedge clk);
        chk("R8 wraps to port0", port_grant, 6'b010101);
        chk("R7 port0 engine", port_eng[0*EW +: EW], 2);
        @(negedge clk);
        chk("R6 all bindings seen", sbq.size(), 0);
        req_valid = '0;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule